// File: doc/BRIEF.md
# Flash Bus-Interface Front End

This block sits on the device side of a partitioned NOR-style flash memory, between the package pins and the internal command and array logic. It watches the active-low chip-enable, output-enable, write-enable, address-valid and reset strobes and sorts each bus state into one of five cycle kinds. From that cycle kind it produces the enables for the data bus and the WAIT pin. Each three-state pin appears as a value plus an output-enable bit.

The block holds an address latch with two behaviours, selected by a mode bit. In asynchronous mode the latch is transparent while address-valid is low and holds its value once address-valid rises. In synchronous mode it captures once per address-valid window, at the first qualified clock edge. If no edge in the window qualified, it captures when address-valid rises. The top bits of the latched address give a partition index. When write-enable rises at the end of a write cycle, the block hands the latched address and the written data to downstream logic with a one-cycle strobe.

All pins are sampled on `clk`. `rstN` is both the device reset pin and the block's asynchronous reset.

Top module: `flash_bus_front`

## Requirements
- R1: `cycleKind` is 0 while rstN is low (reset), 1 when ceN is high (standby), 4 when weN is low (write), 3 when oeN is low with weN high (read), and 2 otherwise (output disable). The checks are made in that priority order.
- R2: `dqOe` is 1 only in a read cycle, and then `dqOut` equals `rdData`. In every other cycle kind `dqOe` is 0.
- R3: `waitOe` is 1 only in a read cycle. In asynchronous mode `waitOut` is 0 during a read. In synchronous mode `waitOut` follows `waitReq`.
- R4: In asynchronous mode (mode bit 0), while advN is low, `latchedAddr` follows `addrIn` with no clock delay.
- R5: In asynchronous mode, after advN rises, `latchedAddr` keeps the address sampled at the last clock edge that had advN low.
- R6: In synchronous mode (mode bit 1), `latchedAddr` takes `addrIn` at the first clock edge with advN low, weN high and ceN low. Later changes of `addrIn` in the same advN-low window are ignored.
- R7: In synchronous mode, if no edge in an advN-low window qualified, the address sampled at the last low edge is loaded at the edge that sees advN high, provided weN is high and ceN is low at that edge.
- R8: `partition` equals the top 4 bits of `latchedAddr`.
- R9: The mode bit loads from `syncMode` only at clock edges where ceN is high. A change of `syncMode` while ceN is low has no effect.
- R10: When weN is sampled high at the edge after an edge that sampled a write cycle, `cmdStrobe` is 1 for exactly one cycle. During that cycle `cmdAddr` holds the latched address and `cmdData` holds `dqIn` from the last write edge.
- R11: While rstN is low, `latchedAddr` is 0 and `dqOe` and `waitOe` are 0. Reset returns the mode bit to asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low reset pin, asynchronous reset |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| advN | input | 1 | Active-low address valid |
| syncMode | input | 1 | Requested mode, 1 = synchronous |
| addrIn | input | ADDR_W (22) | Address bus |
| dqIn | input | DATA_W (16) | Data bus input value |
| rdData | input | DATA_W (16) | Read data from array side |
| waitReq | input | 1 | Wait request from burst logic |
| dqOut | output | DATA_W (16) | Data bus drive value |
| dqOe | output | 1 | Data bus drive enable |
| waitOut | output | 1 | WAIT pin value |
| waitOe | output | 1 | WAIT pin drive enable |
| cycleKind | output | 3 | Classified cycle kind |
| latchedAddr | output | ADDR_W (22) | Current latched address |
| partition | output | PART_BITS (4) | Partition index |
| cmdStrobe | output | 1 | One-cycle write-capture pulse |
| cmdAddr | output | ADDR_W (22) | Address captured with the write |
| cmdData | output | DATA_W (16) | Data captured with the write |

## Verification
The address latch is driven with four patterns. An asynchronous window where the address changes while advN is still low separates transparency from edge capture. A second asynchronous pattern raises advN and changes the address at the same moment, which shows that the held value is the last low sample. A synchronous window with a mid-window address change separates first-edge capture from a latch that tracks its input. A synchronous window with weN held low forces the rising-edge fallback. Read cycles in both modes, with waitReq set, tell a driven-deasserted WAIT apart from one that passes the request through. A `syncMode` change while the chip is enabled shows whether the mode bit loads at the wrong time.

// File: rtl/flashfe_pkg.sv
package flashfe_pkg;

  typedef enum logic [2:0] {
    CYC_RESET   = 3'd0,
    CYC_STANDBY = 3'd1,
    CYC_OUTDIS  = 3'd2,
    CYC_READ    = 3'd3,
    CYC_WRITE   = 3'd4
  } cycle_e;

  // strobes from control to datapath
  typedef struct packed {
    logic transparent;
    logic loadDirect;
    logic loadShadow;
    logic trackShadow;
    logic holdData;
    logic issueCmd;
  } latchCtl_t;

endpackage

// File: rtl/flashfe_ctrl.sv
module flashfe_ctrl
  import flashfe_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      oeN,
  input  logic      weN,
  input  logic      advN,
  input  logic      syncMode,
  output cycle_e    cycle,
  output latchCtl_t ctl,
  output logic      modeSync,
  output logic      cmdStrobe
);

  logic advLowPrev;
  logic captured;
  logic wasWrite;
  logic qualified;

  always_comb begin
    if (!rstN)      cycle = CYC_RESET;
    else if (ceN)   cycle = CYC_STANDBY;
    else if (!weN)  cycle = CYC_WRITE;
    else if (!oeN)  cycle = CYC_READ;
    else            cycle = CYC_OUTDIS;
  end

  assign qualified = weN && !ceN;

  always_comb begin
    ctl.transparent = !modeSync && !advN;
    ctl.loadDirect  = !advN && (!modeSync || (qualified && !captured));
    ctl.loadShadow  = modeSync && advN && advLowPrev && !captured && qualified;
    ctl.trackShadow = !advN;
    ctl.holdData    = (cycle == CYC_WRITE);
    ctl.issueCmd    = rstN && weN && wasWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSync   <= 1'b0;
      advLowPrev <= 1'b0;
      captured   <= 1'b0;
      wasWrite   <= 1'b0;
      cmdStrobe  <= 1'b0;
    end else begin
      if (ceN) modeSync <= syncMode;
      advLowPrev <= !advN;
      if (advN) captured <= 1'b0;
      else if (modeSync && qualified) captured <= 1'b1;
      wasWrite  <= (cycle == CYC_WRITE);
      cmdStrobe <= ctl.issueCmd;
    end
  end

endmodule

// File: rtl/flashfe_dp.sv
module flashfe_dp
  import flashfe_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int PART_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  latchCtl_t            ctl,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [DATA_W-1:0]    dqIn,
  output logic [ADDR_W-1:0]    addrCur,
  output logic [PART_BITS-1:0] partIdx,
  output logic [ADDR_W-1:0]    cmdAddr,
  output logic [DATA_W-1:0]    cmdData
);

  localparam int PART_LSB = ADDR_W - PART_BITS;

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] shadowReg;
  logic [DATA_W-1:0] dataShadow;

  always_comb begin
    if (!rstN)                addrCur = '0;
    else if (ctl.transparent) addrCur = addrIn;
    else                      addrCur = addrReg;
  end

  generate
    if (PART_BITS > 0) begin : g_part
      assign partIdx = addrCur[ADDR_W-1:PART_LSB];
    end else begin : g_nopart
      assign partIdx = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg    <= '0;
      shadowReg  <= '0;
      dataShadow <= '0;
      cmdAddr    <= '0;
      cmdData    <= '0;
    end else begin
      if (ctl.loadDirect)       addrReg <= addrIn;
      else if (ctl.loadShadow)  addrReg <= shadowReg;
      if (ctl.trackShadow) shadowReg <= addrIn;
      if (ctl.holdData)    dataShadow <= dqIn;
      if (ctl.issueCmd) begin
        cmdAddr <= addrCur;
        cmdData <= dataShadow;
      end
    end
  end

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flashfe_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int PART_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceN,
  input  logic                 oeN,
  input  logic                 weN,
  input  logic                 advN,
  input  logic                 syncMode,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [DATA_W-1:0]    dqIn,
  input  logic [DATA_W-1:0]    rdData,
  input  logic                 waitReq,
  output logic [DATA_W-1:0]    dqOut,
  output logic                 dqOe,
  output logic                 waitOut,
  output logic                 waitOe,
  output logic [2:0]           cycleKind,
  output logic [ADDR_W-1:0]    latchedAddr,
  output logic [PART_BITS-1:0] partition,
  output logic                 cmdStrobe,
  output logic [ADDR_W-1:0]    cmdAddr,
  output logic [DATA_W-1:0]    cmdData
);

  cycle_e    cycle;
  latchCtl_t ctl;
  logic      modeSync;
  logic      readCyc;

  flashfe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .advN(advN),
    .syncMode(syncMode), .cycle(cycle), .ctl(ctl), .modeSync(modeSync),
    .cmdStrobe(cmdStrobe)
  );

  flashfe_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PART_BITS(PART_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrIn(addrIn), .dqIn(dqIn),
    .addrCur(latchedAddr), .partIdx(partition), .cmdAddr(cmdAddr),
    .cmdData(cmdData)
  );

  assign readCyc   = (cycle == CYC_READ);
  assign cycleKind = cycle;
  assign dqOe      = readCyc;
  assign dqOut     = rdData;
  assign waitOe    = readCyc;
  assign waitOut   = readCyc && modeSync && waitReq;

endmodule

// File: rtl/flashfe_chk.sv
module flashfe_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              advN,
  input logic              modeSync,
  input logic              dqOe,
  input logic              waitOe,
  input logic              waitOut,
  input logic              cmdStrobe,
  input logic [ADDR_W-1:0] latchedAddr
);

  always_comb begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!dqOe && !waitOe && latchedAddr == '0); // R11
    end
  end

  AST_DQ_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (!ceN && !oeN && weN)); // R2

  AST_WAIT_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    waitOe |-> (!ceN && !oeN && weN)); // R3

  AST_ASYNC_WAIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (waitOe && !modeSync) |-> !waitOut); // R3

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe); // R10

  AST_CMD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> ($past(weN) && $past(!weN && !ceN, 2))); // R10

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modeSync && !advN && !ceN && $past(!advN && modeSync && weN && !ceN))
      |=> $stable(latchedAddr)); // R6

endmodule

bind flash_bus_front flashfe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .advN(advN),
  .modeSync(modeSync), .dqOe(dqOe), .waitOe(waitOe), .waitOut(waitOut),
  .cmdStrobe(cmdStrobe), .latchedAddr(latchedAddr)
);

// File: tb/tb_flash_bus_front.sv
module tb_flash_bus_front;

  localparam int AW = 22;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN, ceN, oeN, weN, advN, syncMode, waitReq;
  logic [AW-1:0] addrIn;
  logic [DW-1:0] dqIn, rdData;
  logic [DW-1:0] dqOut;
  logic dqOe, waitOut, waitOe, cmdStrobe;
  logic [2:0] cycleKind;
  logic [AW-1:0] latchedAddr, cmdAddr;
  logic [3:0] partition;
  logic [DW-1:0] cmdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_bus_front dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .advN(advN),
    .syncMode(syncMode), .addrIn(addrIn), .dqIn(dqIn), .rdData(rdData),
    .waitReq(waitReq), .dqOut(dqOut), .dqOe(dqOe), .waitOut(waitOut),
    .waitOe(waitOe), .cycleKind(cycleKind), .latchedAddr(latchedAddr),
    .partition(partition), .cmdStrobe(cmdStrobe), .cmdAddr(cmdAddr),
    .cmdData(cmdData)
  );

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t sbq[$];
  event sampleEv;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return {29'd0, cycleKind};
      1: return {31'd0, dqOe};
      2: return {16'd0, dqOut};
      3: return {31'd0, waitOe};
      4: return {31'd0, waitOut};
      5: return {10'd0, latchedAddr};
      6: return {28'd0, partition};
      7: return {31'd0, cmdStrobe};
      8: return {10'd0, cmdAddr};
      default: return {16'd0, cmdData};
    endcase
  endfunction

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(sampleEv);
      #1;
      while (sbq.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sbq.pop_front();
        got = observe(it.sel);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic expectv(string req, int sel, logic [31:0] v);
    item_t it;
    it.req = req; it.sel = sel; it.exp = v;
    sbq.push_back(it);
  endtask

  task automatic sample();
    -> sampleEv;
    #2;
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] partOf(logic [AW-1:0] a);
    return {28'd0, a[AW-1:AW-4]};
  endfunction

  localparam logic [AW-1:0] A1 = 22'h2C0011;
  localparam logic [AW-1:0] A2 = 22'h1F00A5;
  localparam logic [AW-1:0] A3 = 22'h055555;
  localparam logic [AW-1:0] A4 = 22'h3ABCDE;
  localparam logic [AW-1:0] B1 = 22'h1234AB;
  localparam logic [AW-1:0] B2 = 22'h300001;
  localparam logic [AW-1:0] C1 = 22'h0ABC00;
  localparam logic [AW-1:0] C2 = 22'h2EEE77;
  localparam logic [AW-1:0] C3 = 22'h111111;
  localparam logic [AW-1:0] D1 = 22'h3F0F0F;

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; ceN = 1; oeN = 1; weN = 1; advN = 1; syncMode = 0; waitReq = 0;
    addrIn = '0; dqIn = '0; rdData = '0;
    tick(2);
    // R11 / R1 reset state
    oeN = 0; ceN = 0;
    expectv("R1", 0, 0); expectv("R11", 5, 0); expectv("R11", 1, 0); expectv("R11", 3, 0);
    sample();
    oeN = 1; ceN = 1; rstN = 1;
    tick();
    expectv("R1", 0, 1); expectv("R2", 1, 0); expectv("R3", 3, 0);
    sample();
    ceN = 0;
    expectv("R1", 0, 2); expectv("R2", 1, 0);
    sample();
    // R4 transparency in async mode
    advN = 0; addrIn = A1;
    expectv("R4", 5, A1); expectv("R8", 6, partOf(A1));
    sample();
    tick();
    addrIn = A2;
    expectv("R4", 5, A2); expectv("R8", 6, partOf(A2));
    sample();
    // R5 hold after advN rise
    tick();
    advN = 1; addrIn = A3;
    expectv("R5", 5, A2);
    sample();
    tick();
    expectv("R5", 5, A2);
    sample();
    // async read
    oeN = 0; rdData = 16'h1234; waitReq = 1;
    expectv("R1", 0, 3); expectv("R2", 1, 1); expectv("R2", 2, 16'h1234);
    expectv("R3", 3, 1); expectv("R3", 4, 0);
    sample();
    // R10 write capture
    oeN = 1; weN = 0; advN = 0; addrIn = A4; dqIn = 16'hBEEF;
    expectv("R1", 0, 4); expectv("R2", 1, 0); expectv("R3", 3, 0); expectv("R10", 7, 0);
    sample();
    tick();
    weN = 1; advN = 1; dqIn = 16'h0000; addrIn = A1;
    expectv("R10", 7, 0);
    sample();
    tick();
    expectv("R10", 7, 1); expectv("R10", 8, A4); expectv("R10", 9, 16'hBEEF);
    sample();
    tick();
    expectv("R10", 7, 0);
    sample();
    // R9 mode ignored while enabled
    syncMode = 1; oeN = 0; waitReq = 1;
    tick(2);
    expectv("R9", 3, 1); expectv("R9", 4, 0);
    sample();
    ceN = 1; oeN = 1;
    tick();
    ceN = 0; syncMode = 0; oeN = 0;
    tick();
    expectv("R9", 4, 1); expectv("R3", 3, 1); expectv("R1", 0, 3);
    sample();
    waitReq = 0;
    expectv("R3", 4, 0);
    sample();
    // R6 synchronous first-edge capture
    oeN = 1; advN = 0; addrIn = B1;
    expectv("R6", 5, A4);
    sample();
    tick();
    expectv("R6", 5, B1);
    sample();
    addrIn = B2;
    tick();
    expectv("R6", 5, B1); expectv("R8", 6, partOf(B1));
    sample();
    advN = 1;
    tick();
    // R7 fallback capture on advN rise
    weN = 0; advN = 0; addrIn = C1;
    tick();
    addrIn = C2;
    tick();
    advN = 1; weN = 1; addrIn = C3;
    expectv("R7", 5, B1);
    sample();
    tick();
    expectv("R7", 5, C2); expectv("R8", 6, partOf(C2));
    sample();
    // R11 reset clears address and mode
    rstN = 0; oeN = 0;
    expectv("R11", 5, 0); expectv("R11", 1, 0); expectv("R11", 3, 0); expectv("R1", 0, 0);
    sample();
    tick();
    rstN = 1; oeN = 1; ceN = 1;
    tick();
    ceN = 0; advN = 0; addrIn = D1;
    expectv("R11", 5, D1);
    sample();
    tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule